// File: doc/BRIEF.md
# Circular Log Buffer Address Manager

This block hands out memory write addresses for fixed-size log records. The records sit in a region of memory that is set up by a base address and a limit address. Each record-write pulse from a trigger source causes one memory write at the current pointer. After that write the pointer moves forward by one word. When the next word would lie above the limit, the pointer goes back to the base.

A loop-enable input selects one of two policies.

- **Loop mode:** writing goes on without end and overwrites the oldest records.
- **Stop mode:** the block stops accepting records once the region has been filled, until software reloads the pointer.

A sticky wrapped flag reports that the region has been filled at least once. The flag has its own clear pulse. A reload pulse moves the pointer back to the base at any time. The pointer itself is always readable as the address of the next record.

The block keeps no memory. It drives a registered write-enable and write-address pair toward the memory. The contents of each record come from elsewhere.

Top module: `logring_addr`

## Requirements
- R1: After a synchronous reset the next-write address is 0, the wrapped flag is 0 and the write enable is 0.
- R2: An accepted record pulse gives exactly one cycle of `wr_en` = 1 on the following cycle. That write is at the address `next_addr` showed in the pulse cycle. `next_addr` then advances by 4 bytes.
- R3: The region is made of the words base, base+4, and so on, up to the last word whose address is at or below the limit. When a write lands on that last word, `next_addr` returns to the base.
- R4: The wrapped flag goes to 1 on the cycle after a write to the last word. It then stays at 1, including across reloads, until it is cleared.
- R5: A clear pulse drives the wrapped flag to 0 on the following cycle, provided no write to the last word happens in the same cycle.
- R6: When a clear pulse and a write to the last word happen in the same cycle, the wrapped flag ends at 1.
- R7: With loop disabled, a write to the last word still sends `next_addr` back to the base and sets the flag. It also halts the block. While halted, record pulses cause no write and leave `next_addr` unchanged.
- R8: A reload pulse without a record pulse sets `next_addr` to the base on the next cycle, causes no write, and ends a halt.
- R9: When a reload pulse and a record pulse happen in the same cycle, the reload wins. The record is written at the base, and `next_addr` advances from the base under the rules of R3 and R4.
- R10: In a cycle with neither a record pulse nor a reload pulse, the next cycle shows `wr_en` = 0 and an unchanged `next_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_base | input | AW | First word address of the log region |
| cfg_limit | input | AW | Highest byte address the region may use |
| cfg_loop | input | 1 | 1 = wrap and continue, 0 = halt after the region is filled |
| rec_pulse | input | 1 | Request to write one record |
| reload_pulse | input | 1 | Move the pointer back to the base |
| flag_clr | input | 1 | Clear the wrapped flag |
| wr_en | output | 1 | Registered memory write enable |
| wr_addr | output | AW | Registered memory write address |
| wrapped | output | 1 | Sticky wrapped flag |
| next_addr | output | AW | Address the next record will be written to |

## Verification
The assertions take the base to be word aligned and the limit to be at least the base, so the region holds at least one word. The reload property also expects the base to hold still for the cycle after a reload. The stimulus sets the base and limit only while no pulse is active, and always from word-aligned bases with limits at or above them. It sweeps every region size from one to four words with each of the four low limit offsets, under both policies. The properties that depend on the halt state read the block's internal halt register through the bind, rather than recomputing it.

// File: rtl/logring_pkg.sv
package logring_pkg;

  // How the pointer register moves in a given cycle.
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_STEP = 2'd1,
    PTR_LOAD = 2'd2
  } ptr_act_e;

endpackage

// File: rtl/logring_step.sv
// Computes the address after a write at cur_addr.
// Wraps to the base when the following word would exceed the limit.
module logring_step #(
  parameter int AW         = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] nxt_addr,
  output logic          at_end
);
  localparam logic [AW:0] STEP_W = (AW+1)'(STEP_BYTES);

  logic [AW:0] sum;

  always_comb begin
    sum      = {1'b0, cur_addr} + STEP_W;
    at_end   = sum > {1'b0, limit};
    nxt_addr = at_end ? base : sum[AW-1:0];
  end
endmodule

// File: rtl/logring_flag.sv
// Sticky flag. A set in the same cycle as a clear wins.
module logring_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/logring_addr.sv
module logring_addr #(
  parameter int AW         = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_limit,
  input  logic          cfg_loop,
  input  logic          rec_pulse,
  input  logic          reload_pulse,
  input  logic          flag_clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wrapped,
  output logic [AW-1:0] next_addr
);
  import logring_pkg::*;

  logic [AW-1:0] ptr_q;
  logic          halt_q;
  logic [AW-1:0] eff_addr;
  logic [AW-1:0] step_addr;
  logic          step_end;
  logic          accept;
  ptr_act_e      act;

  // A reload in the same cycle overrides the stored pointer and any halt.
  always_comb begin
    eff_addr = reload_pulse ? cfg_base : ptr_q;
    accept   = rec_pulse && (reload_pulse || !halt_q);
    if (accept)            act = PTR_STEP;
    else if (reload_pulse) act = PTR_LOAD;
    else                   act = PTR_HOLD;
  end

  logring_step #(.AW(AW), .STEP_BYTES(STEP_BYTES)) u_step (
    .cur_addr (eff_addr),
    .base     (cfg_base),
    .limit    (cfg_limit),
    .nxt_addr (step_addr),
    .at_end   (step_end)
  );

  logring_flag u_flag (
    .clk (clk),
    .rst (rst),
    .set (accept && step_end),
    .clr (flag_clr),
    .q   (wrapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      halt_q  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_en <= accept;
      if (accept) wr_addr <= eff_addr;
      unique case (act)
        PTR_STEP: begin
          ptr_q  <= step_addr;
          halt_q <= step_end && !cfg_loop;
        end
        PTR_LOAD: begin
          ptr_q  <= cfg_base;
          halt_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign next_addr = ptr_q;
endmodule

// File: rtl/logring_addr_chk.sv
module logring_addr_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] cfg_base,
  input logic          rec_pulse,
  input logic          reload_pulse,
  input logic          flag_clr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          wrapped,
  input logic [AW-1:0] next_addr,
  input logic          halt
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (next_addr == '0 && !wrapped && !wr_en));

  // R2
  record_write_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_pulse && !reload_pulse && !halt) |=> (wr_en && wr_addr == $past(next_addr)));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wrapped && !flag_clr) |=> wrapped);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !rec_pulse) |=> !wrapped);

  // R7
  halted_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_pulse && halt && !reload_pulse) |=> (!wr_en && $stable(next_addr)));

  // R8
  reload_only_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_pulse && !rec_pulse) |=> (!wr_en && next_addr == $past(cfg_base)));

  // R9
  reload_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_pulse && rec_pulse) |=> (wr_en && wr_addr == $past(cfg_base)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rec_pulse && !reload_pulse) |=> (!wr_en && $stable(next_addr)));
endmodule

bind logring_addr logring_addr_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_base     (cfg_base),
  .rec_pulse    (rec_pulse),
  .reload_pulse (reload_pulse),
  .flag_clr     (flag_clr),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wrapped      (wrapped),
  .next_addr    (next_addr),
  .halt         (halt_q)
);

// File: tb/sim_logring_addr.sv
`timescale 1ns/1ps
module sim_logring_addr;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_limit = '0;
  logic          cfg_loop = 1'b1;
  logic          rec_pulse = 1'b0;
  logic          reload_pulse = 1'b0;
  logic          flag_clr = 1'b0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          wrapped;
  logic [AW-1:0] next_addr;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  logring_addr #(.AW(AW), .STEP_BYTES(4)) u0 (
    .clk, .rst, .cfg_base, .cfg_limit, .cfg_loop,
    .rec_pulse, .reload_pulse, .flag_clr,
    .wr_en, .wr_addr, .wrapped, .next_addr
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Drive for one cycle at a falling edge. Return at the next falling edge,
  // after the rising edge has updated the outputs.
  task automatic pulse(input logic r, input logic ld, input logic cl);
    @(negedge clk);
    rec_pulse = r; reload_pulse = ld; flag_clr = cl;
    @(negedge clk);
    rec_pulse = 1'b0; reload_pulse = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic setup(input int b, input int l, input logic lp);
    @(negedge clk);
    cfg_base = AW'(b); cfg_limit = AW'(l); cfg_loop = lp;
    pulse(1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "next_addr", int'(next_addr), 0);
    chk("R1", "wrapped", int'(wrapped), 0);
    chk("R1", "wr_en", int'(wr_en), 0);

    // Sweep: three bases, region sizes of 1..4 words, limit offsets 0..3, both policies.
    for (int bi = 0; bi < 3; bi++)
      for (int n = 1; n <= 4; n++)
        for (int off = 0; off < 4; off++)
          for (int lp = 0; lp < 2; lp++) begin
            int b = bi * 20;
            setup(b, b + 4*(n-1) + off, lp[0]);
            chk("R8", "next_addr after reload", int'(next_addr), b);
            chk("R5", "wrapped after clear", int'(wrapped), 0);
            for (int k = 0; k <= 2*n; k++) begin
              pulse(1'b1, 1'b0, 1'b0);
              if (lp == 1 || k < n) begin
                chk("R2", "wr_en", int'(wr_en), 1);
                chk("R2", "wr_addr", int'(wr_addr), b + 4*(k % n));
                chk("R3", "next_addr", int'(next_addr), b + 4*((k+1) % n));
                chk("R4", "wrapped", int'(wrapped), (k+1 >= n) ? 1 : 0);
              end else begin
                chk("R7", "wr_en while halted", int'(wr_en), 0);
                chk("R7", "next_addr while halted", int'(next_addr), b);
                chk("R7", "wrapped while halted", int'(wrapped), 1);
              end
            end
          end

    // R9: a reload in the same cycle as a record, in the middle of a stream.
    setup(16, 31, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R2", "next_addr mid-stream", int'(next_addr), 24);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R9", "wr_en", int'(wr_en), 1);
    chk("R9", "wr_addr", int'(wr_addr), 16);
    chk("R9", "next_addr", int'(next_addr), 20);
    // R9 with a one-word region: the record at the base wraps immediately.
    setup(40, 43, 1'b1);
    pulse(1'b1, 1'b1, 1'b0);
    chk("R9", "wr_addr single word", int'(wr_addr), 40);
    chk("R9", "next_addr single word", int'(next_addr), 40);
    chk("R9", "wrapped single word", int'(wrapped), 1);

    // R6: a clear in the same cycle as a wrap leaves the flag set.
    setup(0, 7, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R4", "wrapped before end", int'(wrapped), 0);
    pulse(1'b1, 1'b0, 1'b1);
    chk("R6", "wrapped clear+wrap", int'(wrapped), 1);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R5", "wrapped after clear", int'(wrapped), 0);
    // R10: an idle cycle
    pulse(1'b0, 1'b0, 1'b0);
    chk("R10", "wr_en idle", int'(wr_en), 0);
    chk("R10", "next_addr idle", int'(next_addr), 0);

    // R7/R8: a halt is released by a reload; the flag stays set across it.
    setup(8, 15, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R7", "wr_en halted", int'(wr_en), 0);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R8", "wr_en on reload", int'(wr_en), 0);
    chk("R8", "next_addr on reload", int'(next_addr), 8);
    chk("R4", "wrapped across reload", int'(wrapped), 1);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R8", "wr_en after release", int'(wr_en), 1);
    chk("R8", "wr_addr after release", int'(wr_addr), 8);
    chk("R8", "next_addr after release", int'(next_addr), 12);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule